// File: doc/BRIEF.md
# Latch/Register Bus Driver

This block carries a parameterised data word (18 bits by default) from its input bus to its output bus. Each bit has one storage element, and a mode control sets how it behaves. In one mode it is a transparent latch that follows the input. In the other mode it is an edge-triggered register that takes the input on a rising edge of a capture strobe. A separate active-low enable decides whether the outputs drive the bus. This enable never touches the stored word.

The three controls come from outside the system clock domain. Each one passes through a synchronizer before it is used. A capture edge is detected by comparing two consecutive synchronized samples of the strobe. The output side is a data vector plus a per-bit drive-enable vector. A wrapper above this block uses the two vectors to build the high-impedance bus.

Top module: `latch_reg_driver`

## Requirements
- R1: All WIDTH bits share the same three controls. An alternating pattern across every bit is carried unchanged, and every bit of `y_drive` always holds the same value.
- R2: `y_drive` equals the inverse of `oe_n_in`, replicated to WIDTH bits. A change on `oe_n_in` driven before clock edge k shows on `y_drive` after edge k+1.
- R3: While the synchronized `le_n_in` is 0 (transparent mode), the store loads `a_in` on every clock. After each edge, `y_out` equals the `a_in` sampled at that edge.
- R4: While the synchronized `le_n_in` is 1 and no capture edge is detected, `y_out` holds its value whatever `a_in` does.
- R5: While the synchronized `le_n_in` is 1, a detected capture edge loads the `a_in` sampled at that clock edge.
- R6: Toggling `oe_n_in` never changes the stored word. When the outputs are enabled again, they show the word held before.
- R7: If `le_n_in` rises while `cp_in` is already high, the word present at that moment is kept. New data loads only after `cp_in` falls and rises again.
- R8: Synchronous active-high `rst` clears the stored word to 0 and forces `y_drive` to all zeros.
- R9: A capture edge is recognised only when the previous synchronized `cp_in` sample is 0 and the current one is 1. Holding `cp_in` high produces exactly one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_in | input | 1 | Asynchronous capture strobe; rising edge loads in register mode |
| le_n_in | input | 1 | Asynchronous mode select; 0 = transparent, 1 = register |
| oe_n_in | input | 1 | Asynchronous active-low output enable |
| a_in | input | WIDTH | Data input word |
| y_out | output | WIDTH | Stored word |
| y_drive | output | WIDTH | Per-bit drive enable; 1 = bit driven |

## Verification
The bench builds the block with its defaults: WIDTH = 18 and two synchronizer stages. The 18-bit width lets an alternating pattern and random words reach every bit lane. The two-stage depth fixes the control latency at two clocks plus one clock for edge detection, which the bench's cycle model follows exactly. With that latency, directed sequences can place a mode change against a strobe that is already high, hold the strobe high across many data changes, and toggle the enable between loads. Mid-run resets fall on top of random traffic.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

    // Synchronized control bundle (bit order used by the synchronizer vector)
    typedef struct packed {
        logic oe_n;
        logic le_n;
        logic cp;
    } ldrv_ctl_t;

    // Reset value of the control bundle: outputs off, register mode, strobe low
    localparam ldrv_ctl_t CTL_RST = '{oe_n: 1'b1, le_n: 1'b1, cp: 1'b0};

    typedef struct packed {
        logic cp_prev;
    } ldrv_edge_t;

endpackage

// File: rtl/ldrv_sync.sv
module ldrv_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                st_d.stage[i] = RST_VAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.stage[LAST];

endmodule

// File: rtl/ldrv_ctrl.sv
module ldrv_ctrl
    import ldrv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ldrv_ctl_t ctl_s,
    output logic      load_en,
    output logic      drive_on
);
    ldrv_edge_t ed_d, ed_q;
    logic       cp_rise;

    always_comb begin
        ed_d         = ed_q;
        ed_d.cp_prev = ctl_s.cp;
        if (rst) begin
            ed_d.cp_prev = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ed_q <= ed_d;
    end

    // Rising edge: previous sample low, current sample high
    assign cp_rise  = ctl_s.cp & ~ed_q.cp_prev;
    // Transparent mode loads every clock; register mode loads on an edge
    assign load_en  = ~ctl_s.le_n | cp_rise;
    assign drive_on = ~ctl_s.oe_n;

endmodule

// File: rtl/ldrv_store.sv
module ldrv_store #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } store_state_t;

    store_state_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_en) begin
            sr_d.word = din;
        end
        if (rst) begin
            sr_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        sr_q <= sr_d;
    end

    assign dout = sr_q.word;

endmodule

// File: rtl/latch_reg_driver.sv
module latch_reg_driver
    import ldrv_pkg::*;
#(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cp_in,
    input  logic             le_n_in,
    input  logic             oe_n_in,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] y_out,
    output logic [WIDTH-1:0] y_drive
);
    localparam int CTL_W = $bits(ldrv_ctl_t);

    ldrv_ctl_t ctl_raw, ctl_s;
    logic      load_en;
    logic      drive_on;
    logic      le_sync;
    logic      cp_sync;

    assign ctl_raw = '{oe_n: oe_n_in, le_n: le_n_in, cp: cp_in};

    ldrv_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_RST)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_in(ctl_raw),
        .sync_out(ctl_s)
    );

    assign le_sync = ctl_s.le_n;
    assign cp_sync = ctl_s.cp;

    ldrv_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .ctl_s   (ctl_s),
        .load_en (load_en),
        .drive_on(drive_on)
    );

    ldrv_store #(
        .WIDTH(WIDTH)
    ) store_i (
        .clk    (clk),
        .rst    (rst),
        .load_en(load_en),
        .din    (a_in),
        .dout   (y_out)
    );

    // One drive-enable per output bit, all from the shared enable
    for (genvar b = 0; b < WIDTH; b++) begin : g_drv
        assign y_drive[b] = drive_on;
    end

endmodule

// File: rtl/latch_reg_driver_chk.sv
module latch_reg_driver_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] y_out,
    input logic [WIDTH-1:0] y_drive,
    input logic             le_sync,
    input logic             cp_sync,
    input logic             load_en
);
    // R1 / R2: drive enables move together
    a_r1_drive_uniform: assert property (@(posedge clk) disable iff (rst)
        ($countones(y_drive) == 0) || ($countones(y_drive) == WIDTH));

    // R3: transparent mode follows the input one clock later
    a_r3_transparent: assert property (@(posedge clk) disable iff (rst)
        !le_sync |=> (y_out == $past(a_in)));

    // R4: register mode without a load keeps the word
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (le_sync && !load_en) |=> $stable(y_out));

    // R5: a load in register mode takes the input
    a_r5_edge_load: assert property (@(posedge clk) disable iff (rst)
        (le_sync && load_en) |=> (y_out == $past(a_in)));

    // R9: register-mode loads only on a low-to-high strobe sample
    a_r9_edge_only: assert property (@(posedge clk) disable iff (rst)
        (le_sync && load_en) |-> (cp_sync && !$past(cp_sync)));

    // R8: reset clears the word and the drive enables
    a_r8_reset: assert property (@(posedge clk)
        rst |=> ((y_out == '0) && (y_drive == '0)));

endmodule

bind latch_reg_driver latch_reg_driver_chk #(.WIDTH(WIDTH)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .a_in   (a_in),
    .y_out  (y_out),
    .y_drive(y_drive),
    .le_sync(le_sync),
    .cp_sync(cp_sync),
    .load_en(load_en)
);

// File: tb/latch_reg_driver_tb_top.sv
module latch_reg_driver_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cp = 1'b0;
    logic         le_n = 1'b1;
    logic         oe_n = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] y;
    logic [W-1:0] drv;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    latch_reg_driver #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cp_in(cp), .le_n_in(le_n), .oe_n_in(oe_n),
        .a_in(a), .y_out(y), .y_drive(drv)
    );

    // Cycle model built from the requirements: 2-stage control sync (R2),
    // edge = previous sample 0, current 1 (R9), loads per R3/R5, reset R8.
    logic m1cp, m2cp, mprev, m1le, m2le, m1oe, m2oe;
    logic [W-1:0] mst;
    int mtag;

    always @(posedge clk) begin
        if (rst) begin
            m1cp <= 0; m2cp <= 0; mprev <= 0;
            m1le <= 1; m2le <= 1; m1oe <= 1; m2oe <= 1;
            mst <= '0; mtag <= 8;
        end else begin
            m1cp <= cp;   m2cp <= m1cp; mprev <= m2cp;
            m1le <= le_n; m2le <= m1le;
            m1oe <= oe_n; m2oe <= m1oe;
            if (!m2le) begin
                mst <= a; mtag <= 3;
            end else if (m2cp && !mprev) begin
                mst <= a; mtag <= 5;
            end else begin
                mtag <= 4;
            end
        end
    end

    function automatic string tag_name(int t);
        case (t)
            3: return "R3";
            5: return "R5";
            8: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [W-1:0] exp_drive(logic oen);
        return {W{~oen}};
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            chk(tag_name(mtag), y, mst);
            chk("R2", drv, exp_drive(m2oe));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x, z;
        void'($urandom(1234));
        cyc(3);
        chk("R8", y, '0);
        chk("R8", drv, '0);
        rst = 0;
        mon_en = 1;

        // R1 / R3: transparent mode with outputs on
        oe_n = 0; le_n = 0;
        cyc(4);
        a = 18'h2AAAA; cyc(2);
        chk("R1", y, 18'h2AAAA);
        chk("R1", drv, {W{1'b1}});
        a = 18'h15555; cyc(2);
        chk("R1", y, 18'h15555);
        for (int i = 0; i < 30; i++) begin
            a = W'($urandom); cyc(1);
        end

        // R5 / R4: register mode with random strobe and data
        le_n = 1; cyc(4);
        for (int i = 0; i < 400; i++) begin
            a = W'($urandom);
            if ($urandom_range(0, 3) == 0) cp = ~cp;
            cyc(1);
        end

        // R7: mode leaves transparent while strobe already high
        cp = 1; le_n = 0; x = 18'h0BEEF; a = x; cyc(5);
        le_n = 1; cyc(4);
        z = 18'h31234; a = z; cyc(6);
        chk("R7", y, x);
        cp = 0; cyc(4);
        chk("R7", y, x);
        cp = 1; cyc(5);
        chk("R7", y, z);

        // R9: strobe held high gives one load only
        cp = 0; cyc(4);
        x = 18'h1C0DE; a = x; cp = 1; cyc(5);
        chk("R5", y, x);
        for (int i = 0; i < 12; i++) begin
            a = W'($urandom); cyc(1);
        end
        chk("R9", y, x);

        // R6: enable toggles leave the stored word alone
        for (int i = 0; i < 10; i++) begin
            oe_n = ~oe_n; a = W'($urandom); cyc(3);
        end
        oe_n = 1; cyc(4);
        chk("R6", drv, '0);
        chk("R6", y, x);
        oe_n = 0; cyc(4);
        chk("R6", y, x);
        chk("R6", drv, {W{1'b1}});

        // Random mix, with occasional mid-run resets (R8)
        for (int i = 0; i < 4000; i++) begin
            a = W'($urandom);
            if ($urandom_range(0, 2) == 0) cp = ~cp;
            if ($urandom_range(0, 40) == 0) le_n = ~le_n;
            if ($urandom_range(0, 30) == 0) oe_n = ~oe_n;
            rst = ($urandom_range(0, 500) == 0);
            cyc(1);
        end
        rst = 0;
        cyc(5);

        done = 1;
        summary();
        $finish;
    end

endmodule